// File: doc/BRIEF.md
# SECDED Word Protection Codec

This block guards a data word against storage upsets with a Hamming code extended by one overall parity bit, so that any single flipped bit is repaired and any two flipped bits are reported. It has two independent paths. The encode path is purely combinational: a data word goes in and a codeword comes out, ready to be written next to the data in some storage. The decode path takes a codeword read back from storage, qualified by a valid strobe, and one clock later presents the repaired data, the repaired codeword and two status flags.

The codeword layout is fixed by bit position. Codeword bit `p-1` holds position `p`. Positions that are powers of two carry check bits, the remaining positions up to `N = DATA_W + CHECK_W` carry the data bits in ascending order, and the top bit (position `N+1`) is an even parity over everything below it. `CHECK_W` is the smallest count with `2^CHECK_W >= DATA_W + CHECK_W + 1`. A 4-bit word gives an 8-bit codeword and a 64-bit word gives a 72-bit codeword, so the wide configuration is a shortened code whose syndrome can name positions that do not exist.

The decoder accepts a new codeword every cycle. Status is encoded as two flags: neither set means the word was clean, `dec_single_o` means one bit was repaired, and `dec_double_o` means the word cannot be repaired.

Top module: `secded_codec`

## Requirements
- R1: The codeword places check bits at positions 1, 2, 4, 8, ..., fills all other positions from 1 to N with data bits in ascending order (data bit 0 at position 3), and puts at position N+1 (codeword bit N) the even parity of codeword bits 0 to N-1; for a 4-bit word positions 1 to 8 hold C1, C2, d0, C3, d1, d2, d3, P.
- R2: The check bit at position 2^j is the even parity of all data positions whose index has bit j set.
- R3: A codeword with zero syndrome and even overall parity is returned with both flags low and with data and codeword unchanged.
- R4: A codeword with one flipped data position raises dec_single_o only, returns the original data and the original codeword.
- R5: A codeword with one flipped check-bit position raises dec_single_o only, returns the data untouched and the codeword with that check bit restored.
- R6: A codeword whose only flipped bit is the overall parity bit raises dec_single_o only, returns the data untouched and the codeword with the parity bit restored.
- R7: A nonzero syndrome with even overall parity raises dec_double_o only, and the codeword is returned as received.
- R8: In a shortened code, a syndrome larger than N with odd overall parity raises dec_double_o only, and the codeword is returned as received.
- R9: dec_valid_o is high exactly one cycle after dec_valid_i, back-to-back codewords are each reported in the following cycle, and data and codeword outputs hold while no codeword arrives, with both flags low.
- R10: During and right after reset, dec_valid_o, dec_single_o and dec_double_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_data_i | input | DATA_W | Data word to encode |
| enc_code_o | output | DATA_W+CHECK_W+1 | Codeword for enc_data_i |
| dec_valid_i | input | 1 | A codeword is presented on dec_code_i |
| dec_code_i | input | DATA_W+CHECK_W+1 | Codeword read back from storage |
| dec_valid_o | output | 1 | Decode results are valid this cycle |
| dec_data_o | output | DATA_W | Repaired data word |
| dec_code_o | output | DATA_W+CHECK_W+1 | Repaired codeword |
| dec_single_o | output | 1 | One bit was repaired |
| dec_double_o | output | 1 | Word is uncorrectable |

## Verification
The 4-bit configuration is driven exhaustively: every data value is encoded and compared with the check-bit equations written out by hand, then every single-bit flip and every pair of flips is decoded, which separates data, check-bit and parity-bit repair from double-error detection. The 64-bit configuration is tried with walking, alternating and all-ones data, with flips placed in data, check and parity positions, and with a three-bit flip whose syndrome points beyond the last used position, which tells the shortened-code case apart from an ordinary repair. A back-to-back burst followed by an idle cycle tells per-cycle throughput and output holding apart from stale results.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_SINGLE = 2'd1,
    ERR_DOUBLE = 2'd2
  } err_kind_e;

  // Smallest number of Hamming check bits covering dw data bits plus
  // themselves plus the zero syndrome.
  function automatic int check_bits(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  function automatic bit is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
#(
  parameter  int DW = 64,
  localparam int CB = check_bits(DW),
  localparam int N  = DW + CB,
  localparam int CW = N + 1
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] code_o
);

  function automatic logic [CW-1:0] encode(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p <= N; p++) begin
      if (!is_pow2(p)) begin
        c[p-1] = d[k];
        k++;
      end
    end
    for (int j = 0; j < CB; j++) begin
      logic b;
      b = 1'b0;
      for (int p = 1; p <= N; p++) begin
        if (((p >> j) & 1) == 1 && !is_pow2(p)) b ^= c[p-1];
      end
      c[(1 << j) - 1] = b;
    end
    c[N] = ^c[N-1:0];
    return c;
  endfunction

  assign code_o = encode(data_i);

endmodule

// File: rtl/secded_chk.sv
module secded_chk
  import secded_pkg::*;
#(
  parameter  int DW = 64,
  localparam int CB = check_bits(DW),
  localparam int N  = DW + CB,
  localparam int CW = N + 1
) (
  input  logic [CW-1:0] code_i,
  output logic [CB-1:0] syn_o,
  output logic          par_fail_o,
  output err_kind_e     kind_o,
  output logic [CW-1:0] fix_code_o,
  output logic [DW-1:0] fix_data_o
);

  // XOR of the indices of all set positions: equals received check bits
  // XOR check bits recomputed from the received data.
  function automatic logic [CB-1:0] syndrome(input logic [CW-1:0] c);
    logic [CB-1:0] s;
    s = '0;
    for (int p = 1; p <= N; p++) begin
      if (c[p-1]) s ^= CB'(p);
    end
    return s;
  endfunction

  function automatic err_kind_e classify(input logic [CB-1:0] s, input logic pf);
    if (!pf)               return (s == '0) ? ERR_NONE : ERR_DOUBLE;
    else if (s == '0)      return ERR_SINGLE;
    else if (int'(s) <= N) return ERR_SINGLE;
    else                   return ERR_DOUBLE;
  endfunction

  function automatic logic [DW-1:0] extract(input logic [CW-1:0] c);
    logic [DW-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p <= N; p++) begin
      if (!is_pow2(p)) begin
        d[k] = c[p-1];
        k++;
      end
    end
    return d;
  endfunction

  assign syn_o      = syndrome(code_i);
  assign par_fail_o = ^code_i;
  assign kind_o     = classify(syn_o, par_fail_o);

  always_comb begin
    fix_code_o = code_i;
    if (kind_o == ERR_SINGLE) begin
      if (syn_o == '0) fix_code_o[N] = ~code_i[N];
      else             fix_code_o[int'(syn_o) - 1] = ~code_i[int'(syn_o) - 1];
    end
  end

  assign fix_data_o = extract(fix_code_o);

endmodule

// File: rtl/secded_out_reg.sv
module secded_out_reg
  import secded_pkg::*;
#(
  parameter int DW = 64,
  parameter int CW = 72
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  err_kind_e     kind_i,
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] code_i,
  output logic          valid_o,
  output logic          single_o,
  output logic          double_o,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] code_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      single_o <= 1'b0;
      double_o <= 1'b0;
      data_o   <= '0;
      code_o   <= '0;
    end else begin
      valid_o  <= valid_i;
      single_o <= valid_i && (kind_i == ERR_SINGLE);
      double_o <= valid_i && (kind_i == ERR_DOUBLE);
      if (valid_i) begin
        data_o <= data_i;
        code_o <= code_i;
      end
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (!valid_o && !single_o && !double_o));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(data_o) && $stable(code_o)));
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({single_o, double_o}));

endmodule

// File: rtl/secded_codec.sv
module secded_codec
  import secded_pkg::*;
#(
  parameter  int DATA_W  = 64,
  localparam int CHECK_W = check_bits(DATA_W),
  localparam int CODE_W  = DATA_W + CHECK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic [CODE_W-1:0] enc_code_o,
  input  logic              dec_valid_i,
  input  logic [CODE_W-1:0] dec_code_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic [CODE_W-1:0] dec_code_o,
  output logic              dec_single_o,
  output logic              dec_double_o
);

  logic [CHECK_W-1:0] syn;
  logic               par_fail;
  err_kind_e          kind;
  logic [CODE_W-1:0]  fix_code;
  logic [DATA_W-1:0]  fix_data;

  secded_enc #(.DW(DATA_W)) u_enc (
    .data_i (enc_data_i),
    .code_o (enc_code_o)
  );

  secded_chk #(.DW(DATA_W)) u_chk (
    .code_i     (dec_code_i),
    .syn_o      (syn),
    .par_fail_o (par_fail),
    .kind_o     (kind),
    .fix_code_o (fix_code),
    .fix_data_o (fix_data)
  );

  secded_out_reg #(.DW(DATA_W), .CW(CODE_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (dec_valid_i),
    .kind_i   (kind),
    .data_i   (fix_data),
    .code_i   (fix_code),
    .valid_o  (dec_valid_o),
    .single_o (dec_single_o),
    .double_o (dec_double_o),
    .data_o   (dec_data_o),
    .code_o   (dec_code_o)
  );

  // A repair touches exactly one codeword bit.
  a_r4_one_bit_repair: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dec_valid_i) && dec_single_o |-> $countones(dec_code_o ^ $past(dec_code_i)) == 1);
  // Clean and uncorrectable words pass through unchanged.
  a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o && !dec_single_o |-> dec_code_o == $past(dec_code_i));
  // A repaired word always had odd overall parity on arrival.
  a_r6_single_needs_odd: assert property (@(posedge clk) disable iff (!rst_n)
    dec_single_o |-> (^$past(dec_code_i)) == 1'b1);
  // A clean result always had even overall parity on arrival.
  a_r7_clean_even: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o && !dec_single_o && !dec_double_o |-> (^$past(dec_code_i)) == 1'b0);

endmodule

// File: tb/tb_secded_codec.sv
`timescale 1ns/1ps
module tb_secded_codec;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;

  // 64-bit configuration
  logic [63:0] e64_d;
  logic [71:0] e64_c;
  logic        v64_i;
  logic [71:0] c64_i;
  logic        v64_o, s64_o, d64_o;
  logic [63:0] dat64_o;
  logic [71:0] cod64_o;

  secded_codec #(.DATA_W(64)) dut (
    .clk(clk), .rst_n(rst_n),
    .enc_data_i(e64_d), .enc_code_o(e64_c),
    .dec_valid_i(v64_i), .dec_code_i(c64_i),
    .dec_valid_o(v64_o), .dec_data_o(dat64_o), .dec_code_o(cod64_o),
    .dec_single_o(s64_o), .dec_double_o(d64_o)
  );

  // 4-bit configuration
  logic [3:0] e4_d;
  logic [7:0] e4_c;
  logic       v4_i;
  logic [7:0] c4_i;
  logic       v4_o, s4_o, d4_o;
  logic [3:0] dat4_o;
  logic [7:0] cod4_o;

  secded_codec #(.DATA_W(4)) dut_w4 (
    .clk(clk), .rst_n(rst_n),
    .enc_data_i(e4_d), .enc_code_o(e4_c),
    .dec_valid_i(v4_i), .dec_code_i(c4_i),
    .dec_valid_o(v4_o), .dec_data_o(dat4_o), .dec_code_o(cod4_o),
    .dec_single_o(s4_o), .dec_double_o(d4_o)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Hand-written equations for the 4-bit layout C1 C2 d0 C3 d1 d2 d3 P.
  function automatic logic [7:0] ref4(input logic [3:0] d);
    logic c1, c2, c3, p;
    c1 = d[0] ^ d[1] ^ d[3];
    c2 = d[0] ^ d[2] ^ d[3];
    c3 = d[1] ^ d[2] ^ d[3];
    p  = c1 ^ c2 ^ d[0] ^ c3 ^ d[1] ^ d[2] ^ d[3];
    return {p, d[3], d[2], d[1], c3, d[0], c2, c1};
  endfunction

  // Wide reference: walk positions skipping powers of two, then each check
  // bit is the parity of every position carrying that index bit.
  function automatic logic [71:0] ref64(input logic [63:0] d);
    logic [71:0] c;
    int p;
    c = '0;
    p = 3;
    for (int k = 0; k < 64; k++) begin
      while ((p & (p - 1)) == 0) p++;
      c[p-1] = d[k];
      p++;
    end
    for (int j = 0; j < 7; j++) begin
      logic b;
      b = 1'b0;
      for (int q = 1; q <= 71; q++) if (q[j]) b ^= c[q-1];
      c[(1 << j) - 1] = b;
    end
    c[71] = ^c[70:0];
    return c;
  endfunction

  task automatic dec4(input logic [7:0] code, input logic [3:0] xd, input logic xs,
                      input logic xdbl, input logic [7:0] xc, input string req);
    @(negedge clk);
    v4_i = 1'b1; c4_i = code;
    @(negedge clk);
    v4_i = 1'b0;
    check(v4_o == 1'b1, {req, " valid"}, 128'(v4_o), 128'(1));
    check({s4_o, d4_o} == {xs, xdbl}, {req, " flags"}, 128'({s4_o, d4_o}), 128'({xs, xdbl}));
    check(cod4_o == xc, {req, " code"}, 128'(cod4_o), 128'(xc));
    if (!xdbl) check(dat4_o == xd, {req, " data"}, 128'(dat4_o), 128'(xd));
  endtask

  task automatic dec64(input logic [71:0] code, input logic [63:0] xd, input logic xs,
                       input logic xdbl, input logic [71:0] xc, input string req);
    @(negedge clk);
    v64_i = 1'b1; c64_i = code;
    @(negedge clk);
    v64_i = 1'b0;
    check(v64_o == 1'b1, {req, " valid"}, 128'(v64_o), 128'(1));
    check({s64_o, d64_o} == {xs, xdbl}, {req, " flags"}, 128'({s64_o, d64_o}), 128'({xs, xdbl}));
    check(cod64_o == xc, {req, " code"}, 128'(cod64_o), 128'(xc));
    if (!xdbl) check(dat64_o == xd, {req, " data"}, 128'(dat64_o), 128'(xd));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check({v64_o, s64_o, d64_o} == 3'b000, "R10 wide outputs in reset", 128'({v64_o, s64_o, d64_o}), 128'(0));
    check({v4_o, s4_o, d4_o} == 3'b000, "R10 narrow outputs in reset", 128'({v4_o, s4_o, d4_o}), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check({v64_o, s64_o, d64_o, v4_o, s4_o, d4_o} == 6'b0, "R10 outputs after reset",
          128'({v64_o, s64_o, d64_o, v4_o, s4_o, d4_o}), 128'(0));
  endtask

  task automatic t_enc4();
    for (int v = 0; v < 16; v++) begin
      e4_d = 4'(v);
      #1;
      check(e4_c == ref4(4'(v)), "R1 R2 narrow encode", 128'(e4_c), 128'(ref4(4'(v))));
    end
  endtask

  task automatic t_enc64();
    logic [63:0] pats [5];
    pats[0] = 64'h0; pats[1] = 64'hFFFF_FFFF_FFFF_FFFF; pats[2] = 64'hAAAA_5555_0F0F_F0F0;
    pats[3] = 64'h8000_0000_0000_0001; pats[4] = 64'h0123_4567_89AB_CDEF;
    for (int i = 0; i < 5; i++) begin
      e64_d = pats[i];
      #1;
      check(e64_c == ref64(pats[i]), "R1 R2 wide encode", 128'(e64_c), 128'(ref64(pats[i])));
    end
  endtask

  task automatic t_narrow_decode();
    for (int v = 0; v < 16; v++) begin
      logic [7:0] good;
      good = ref4(4'(v));
      dec4(good, 4'(v), 1'b0, 1'b0, good, "R3 narrow clean");
      for (int p = 1; p <= 8; p++) begin
        logic [7:0] bad;
        bad = good ^ (8'd1 << (p - 1));
        if (p == 8)                    dec4(bad, 4'(v), 1'b1, 1'b0, good, "R6 narrow parity flip");
        else if (p == 1 || p == 2 || p == 4) dec4(bad, 4'(v), 1'b1, 1'b0, good, "R5 narrow check flip");
        else                           dec4(bad, 4'(v), 1'b1, 1'b0, good, "R4 narrow data flip");
      end
      for (int a = 1; a <= 8; a++)
        for (int b = a + 1; b <= 8; b++) begin
          logic [7:0] bad2;
          bad2 = good ^ (8'd1 << (a - 1)) ^ (8'd1 << (b - 1));
          dec4(bad2, 4'(v), 1'b0, 1'b1, bad2, "R7 narrow double");
        end
    end
  endtask

  task automatic t_wide_decode();
    logic [63:0] d;
    logic [71:0] g, b;
    d = 64'hDEAD_BEEF_0BAD_F00D;
    g = ref64(d);
    dec64(g, d, 1'b0, 1'b0, g, "R3 wide clean");
    dec64(g ^ (72'd1 << 2), d, 1'b1, 1'b0, g, "R4 wide data flip pos 3");
    dec64(g ^ (72'd1 << 70), d, 1'b1, 1'b0, g, "R4 wide data flip pos 71");
    dec64(g ^ (72'd1 << 31), d, 1'b1, 1'b0, g, "R5 wide check flip pos 32");
    dec64(g ^ (72'd1 << 63), d, 1'b1, 1'b0, g, "R5 wide check flip pos 64");
    dec64(g ^ (72'd1 << 71), d, 1'b1, 1'b0, g, "R6 wide parity flip");
    b = g ^ (72'd1 << 4) ^ (72'd1 << 40);
    dec64(b, d, 1'b0, 1'b1, b, "R7 wide double");
    b = g ^ (72'd1 << 10) ^ (72'd1 << 71);
    dec64(b, d, 1'b0, 1'b1, b, "R7 wide data plus parity");
    // positions 1, 8, 64: syndrome 73 > 71, odd parity
    b = g ^ (72'd1 << 0) ^ (72'd1 << 7) ^ (72'd1 << 63);
    dec64(b, d, 1'b0, 1'b1, b, "R8 wide syndrome past end");
    d = '0; g = ref64(d);
    dec64(g ^ (72'd1 << 5), d, 1'b1, 1'b0, g, "R4 wide zero word flip");
  endtask

  task automatic t_burst();
    logic [63:0] da, db, dc;
    logic [71:0] ga, gb, gc;
    da = 64'h1111_2222_3333_4444; db = 64'h5555_6666_7777_8888; dc = 64'h9999_AAAA_BBBB_CCCC;
    ga = ref64(da); gb = ref64(db); gc = ref64(dc);
    @(negedge clk); v64_i = 1'b1; c64_i = ga;
    @(negedge clk); c64_i = gb ^ (72'd1 << 20);
    check(v64_o && dat64_o == da && !s64_o, "R9 burst first", 128'(dat64_o), 128'(da));
    @(negedge clk); c64_i = gc;
    check(v64_o && dat64_o == db && s64_o, "R9 burst second", 128'(dat64_o), 128'(db));
    @(negedge clk); v64_i = 1'b0; c64_i = ga ^ (72'd1 << 3) ^ (72'd1 << 9);
    check(v64_o && dat64_o == dc && !s64_o, "R9 burst third", 128'(dat64_o), 128'(dc));
    @(negedge clk);
    check(!v64_o && !s64_o && !d64_o, "R9 idle flags low", 128'({v64_o, s64_o, d64_o}), 128'(0));
    check(dat64_o == dc && cod64_o == gc, "R9 idle hold", 128'(dat64_o), 128'(dc));
  endtask

  initial begin
    e64_d = '0; v64_i = 1'b0; c64_i = '0;
    e4_d = '0; v4_i = 1'b0; c4_i = '0;
    t_reset();
    t_enc4();
    t_enc64();
    t_narrow_decode();
    t_wide_decode();
    t_burst();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 20000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule